// File: doc/BRIEF.md
# Receive Frame Ring Writer

This block stores received frames into a circular byte buffer in local memory. It is fed a byte stream with start and end markers. Error and address-class indications are valid with the last byte. Each frame it keeps gets a four-byte descriptor word in front of its data. The descriptor holds a status half-word and the frame length, which includes the 4-byte FCS. Every descriptor starts on a four-byte boundary. The next descriptor position is the current one plus length plus four, rounded up to a multiple of four.

The host consumes frames and reports progress through a read-pointer register. The host writes its consumed offset minus 16 into that register. The block compares the write pointer with that offset to drive a buffer-empty flag. It refuses any frame whose footprint would reach unread data, and raises an overflow interrupt flag instead. The descriptor is written only after the final data byte has arrived. The write pointer moves one cycle after the descriptor's last byte, so a host never sees a partly written frame.

The ring size is 8 KiB shifted left by a two-bit index; the values 0, 1 and 2 are used. The memory side is a registered byte-wide write port. The sender keeps at least five idle cycles between the last byte of one frame and the first byte of the next.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, the write pointer is 0 and the buffer reads as empty. Both interrupt flags are 0, and no memory write is issued.
- R2: Data byte i of a frame starting at offset S is written at (S + 4 + i) modulo the ring length. The ring length is 8192 << size index. All addresses stay below the ring length.
- R3: The descriptor is written little-endian at S: bits 15:0 are status and bits 31:16 are the byte count including FCS. All four descriptor bytes are written before the write pointer changes.
- R4: Status bit 0 is set when the frame has no error, runt or too-long condition. Bit 1 is alignment error and bit 2 is CRC error. Bit 3 is too long (count > 1518). Bit 4 is runt (count < 64). Bit 5 is bad symbol. Bit 13 is broadcast, bit 14 is own-address match and bit 15 is multicast.
- R5: A committed frame moves the write pointer to (S + count + 4 + 3) with bits 1:0 cleared, modulo the ring length.
- R6: A frame passes the address filter in any of these cases: it is broadcast and accept bit 3 is set; it is multicast and bit 2 is set; it matches the own address and bit 1 is set; or bit 0 (any unicast) is set and the frame is neither broadcast nor multicast.
- R7: Frames with an alignment, CRC, bad-symbol or too-long condition are kept only if accept bit 5 is set. Runts are kept only if accept bit 4 is set.
- R8: The read offset is (register value + 16) modulo the ring length; the register resets to 0xFFF0. buf_empty is 1 exactly when the write pointer equals the read offset.
- R9: A kept frame whose rounded footprint (count + 4 rounded up to 4) is not smaller than the free space raises irq_ovf and is dropped. Free space is the distance to the read offset, or the full ring when empty. A dropped frame gets no descriptor, leaves the write pointer unchanged, and no byte is written at or beyond the read offset.
- R10: Each commit sets irq_rok (status bit 0). Writing 1 to bit 0 or bit 4 of the interrupt clear port clears irq_rok or irq_ovf. A set in the same cycle as a clear wins.
- R11: A rejected frame changes neither the write pointer nor irq_rok.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size | input | 2 | Ring size index (0..2) |
| cfg_accept | input | 6 | Accept enables: 0 any unicast, 1 own address, 2 multicast, 3 broadcast, 4 runts, 5 error frames |
| in_valid | input | 1 | Byte valid |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame; flags below valid |
| in_data | input | 8 | Frame byte |
| in_err_align | input | 1 | Alignment error |
| in_err_crc | input | 1 | CRC error |
| in_err_symbol | input | 1 | Bad symbol seen |
| in_bcast | input | 1 | Broadcast destination |
| in_mcast | input | 1 | Multicast destination |
| in_phys | input | 1 | Destination equals own address |
| host_rp_we | input | 1 | Read-pointer register write |
| host_rp_data | input | 16 | Consumed offset minus 16 |
| host_ic_we | input | 1 | Interrupt clear write |
| host_ic_data | input | 16 | Write-one-to-clear mask (bit 0 ok, bit 4 overflow) |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 15 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| wr_ptr | output | 15 | Offset of next descriptor |
| buf_empty | output | 1 | No unread frame remains |
| irq_rok | output | 1 | Frame committed flag |
| irq_ovf | output | 1 | Frame dropped for lack of space |

## Verification
The commit of a frame, which sets irq_rok, can fall in the same cycle as a host write-one-to-clear on the interrupt port. The bench provokes this by timing a clear of both flags onto the commit cycle. That cycle is counted from the end-of-frame byte through the four descriptor cycles. The result is judged by irq_rok still being 1 afterwards while irq_ovf, which had no set pending, reads 0. The overflow case is set up by placing the read offset 64 bytes ahead of the write pointer. Sentinel bytes at the read offset must survive, and a smaller frame must still fit afterwards.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int HDR_LEN_W = 16;

  localparam int ST_OK     = 0;
  localparam int ST_ALIGN  = 1;
  localparam int ST_CRC    = 2;
  localparam int ST_LONG   = 3;
  localparam int ST_RUNT   = 4;
  localparam int ST_SYMBOL = 5;
  localparam int ST_BCAST  = 13;
  localparam int ST_PHYS   = 14;
  localparam int ST_MCAST  = 15;

  localparam int ACC_ANY   = 0;
  localparam int ACC_OWN   = 1;
  localparam int ACC_MC    = 2;
  localparam int ACC_BC    = 3;
  localparam int ACC_RUNT  = 4;
  localparam int ACC_ERR   = 5;

  localparam int IRQ_ROK_BIT = 0;
  localparam int IRQ_OVF_BIT = 4;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_DATA   = 2'd1,
    S_HDR    = 2'd2,
    S_COMMIT = 2'd3
  } rxr_state_e;
endpackage

// File: rtl/rxr_frame_filter.sv
module rxr_frame_filter #(
  parameter int LEN_W     = 16,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518
) (
  input  logic [LEN_W-1:0] len,
  input  logic             err_align,
  input  logic             err_crc,
  input  logic             err_symbol,
  input  logic             is_bc,
  input  logic             is_mc,
  input  logic             is_phys,
  input  logic [5:0]       accept,
  output logic [15:0]      status,
  output logic             keep
);
  import rxr_pkg::*;

  logic runt, too_long, hard_err, addr_ok;

  always_comb begin
    runt     = (len < LEN_W'(MIN_FRAME));
    too_long = (len > LEN_W'(MAX_FRAME));
    hard_err = err_align | err_crc | err_symbol | too_long;

    status             = '0;
    status[ST_OK]      = ~(hard_err | runt);
    status[ST_ALIGN]   = err_align;
    status[ST_CRC]     = err_crc;
    status[ST_LONG]    = too_long;
    status[ST_RUNT]    = runt;
    status[ST_SYMBOL]  = err_symbol;
    status[ST_BCAST]   = is_bc;
    status[ST_PHYS]    = is_phys;
    status[ST_MCAST]   = is_mc;

    addr_ok = (is_bc & accept[ACC_BC]) |
              (is_mc & accept[ACC_MC]) |
              (is_phys & accept[ACC_OWN]) |
              (accept[ACC_ANY] & ~is_bc & ~is_mc);

    keep = addr_ok & (~hard_err | accept[ACC_ERR]) & (~runt | accept[ACC_RUNT]);
  end
endmodule

// File: rtl/rxr_space_tracker.sv
module rxr_space_tracker #(
  parameter int BASE_LOG2 = 13,
  parameter int MAX_IDX   = 2,
  parameter int ADDR_W    = 15,
  parameter int RP_W      = 16,
  parameter int RP_BIAS   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        size,
  input  logic              rp_we,
  input  logic [RP_W-1:0]   rp_data,
  input  logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] rd_off,
  output logic [ADDR_W:0]   free,
  output logic              empty
);
  localparam int FREE_W = ADDR_W + 1;
  localparam logic [RP_W-1:0] RP_INIT = RP_W'(0) - RP_W'(RP_BIAS);

  logic [RP_W-1:0]   rp_q;
  logic [RP_W-1:0]   rp_sum;
  logic [1:0]        idx;
  logic [ADDR_W-1:0] diff;
  logic              unused_rp;

  always_ff @(posedge clk) begin
    if (rst)        rp_q <= RP_INIT;
    else if (rp_we) rp_q <= rp_data;
  end

  always_comb idx = (size > 2'(MAX_IDX)) ? 2'(MAX_IDX) : size;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_mask
    if (b < BASE_LOG2) begin : g_fixed
      assign mask[b] = 1'b1;
    end else begin : g_sel
      assign mask[b] = (int'(idx) > (b - BASE_LOG2));
    end
  end

  always_comb begin
    rp_sum = rp_q + RP_W'(RP_BIAS);
    rd_off = rp_sum[ADDR_W-1:0] & mask;
    diff   = (rd_off - wr_ptr) & mask;
    empty  = (diff == '0);
    free   = empty ? ({1'b0, mask} + FREE_W'(1)) : {1'b0, diff};
  end

  if (RP_W > ADDR_W) begin : g_unused
    assign unused_rp = ^rp_sum[RP_W-1:ADDR_W];
  end else begin : g_nounused
    assign unused_rp = 1'b0;
  end
endmodule

// File: rtl/rxr_irq_flags.sv
module rxr_irq_flags #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NUM-1:0] set_i,
  input  logic [NUM-1:0] clr_i,
  output logic [NUM-1:0] flag_o
);
  for (genvar k = 0; k < NUM; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           flag_o[k] <= 1'b0;
      else if (set_i[k]) flag_o[k] <= 1'b1;
      else if (clr_i[k]) flag_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int BASE_LOG2 = 13,
  parameter int MAX_IDX   = 2,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518,
  parameter int RP_BIAS   = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   cfg_size,
  input  logic [5:0]                   cfg_accept,
  input  logic                         in_valid,
  input  logic                         in_sof,
  input  logic                         in_eof,
  input  logic [7:0]                   in_data,
  input  logic                         in_err_align,
  input  logic                         in_err_crc,
  input  logic                         in_err_symbol,
  input  logic                         in_bcast,
  input  logic                         in_mcast,
  input  logic                         in_phys,
  input  logic                         host_rp_we,
  input  logic [15:0]                  host_rp_data,
  input  logic                         host_ic_we,
  input  logic [15:0]                  host_ic_data,
  output logic                         mem_we,
  output logic [BASE_LOG2+MAX_IDX-1:0] mem_addr,
  output logic [7:0]                   mem_wdata,
  output logic [BASE_LOG2+MAX_IDX-1:0] wr_ptr,
  output logic                         buf_empty,
  output logic                         irq_rok,
  output logic                         irq_ovf
);
  import rxr_pkg::*;

  localparam int ADDR_W = BASE_LOG2 + MAX_IDX;
  localparam int LEN_W  = HDR_LEN_W;
  localparam int CMP_W  = LEN_W + 3;

  rxr_state_e        state_q;
  logic [ADDR_W-1:0] ring_mask, rd_off, wr_ptr_q, cur_q, next_q;
  logic [ADDR_W-1:0] base_ptr, byte_addr, next_ptr;
  logic [ADDR_W:0]   free_bytes;
  logic              empty_w;
  logic [LEN_W-1:0]  cnt_q, offs, new_len;
  logic [CMP_W-1:0]  rel_pos, footprint;
  logic              trunc_q, trunc_total, can_write, fits;
  logic              frame_byte, frame_end, keep_w;
  logic              ovf_set, rok_set;
  logic [15:0]       status_w;
  logic [31:0]       hdr_q;
  logic [1:0]        hidx_q;
  logic [1:0]        irq_vec;
  logic              mem_we_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic [7:0]        mem_wdata_q;
  logic              unused_ic;

  rxr_space_tracker #(
    .BASE_LOG2(BASE_LOG2), .MAX_IDX(MAX_IDX), .ADDR_W(ADDR_W),
    .RP_W(16), .RP_BIAS(RP_BIAS)
  ) u_space (
    .clk(clk), .rst(rst), .size(cfg_size),
    .rp_we(host_rp_we), .rp_data(host_rp_data), .wr_ptr(wr_ptr_q),
    .mask(ring_mask), .rd_off(rd_off), .free(free_bytes), .empty(empty_w)
  );

  rxr_frame_filter #(
    .LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME)
  ) u_filter (
    .len(new_len), .err_align(in_err_align), .err_crc(in_err_crc),
    .err_symbol(in_err_symbol), .is_bc(in_bcast), .is_mc(in_mcast),
    .is_phys(in_phys), .accept(cfg_accept),
    .status(status_w), .keep(keep_w)
  );

  rxr_irq_flags #(.NUM(2)) u_irq (
    .clk(clk), .rst(rst),
    .set_i({ovf_set, rok_set}),
    .clr_i({host_ic_we & host_ic_data[IRQ_OVF_BIT], host_ic_we & host_ic_data[IRQ_ROK_BIT]}),
    .flag_o(irq_vec)
  );

  assign unused_ic = ^{host_ic_data[15:5], host_ic_data[3:1]};

  always_comb begin
    frame_byte  = in_valid & (((state_q == S_IDLE) & in_sof) | (state_q == S_DATA));
    frame_end   = frame_byte & in_eof;
    base_ptr    = (state_q == S_IDLE) ? wr_ptr_q : cur_q;
    offs        = (state_q == S_IDLE) ? '0 : cnt_q;
    new_len     = (offs == '1) ? offs : offs + LEN_W'(1);
    rel_pos     = CMP_W'(offs) + CMP_W'(4);
    can_write   = rel_pos < CMP_W'(free_bytes);
    byte_addr   = (base_ptr + ADDR_W'(4) + ADDR_W'(offs)) & ring_mask;
    footprint   = (CMP_W'(new_len) + CMP_W'(7)) & ~CMP_W'(3);
    fits        = footprint < CMP_W'(free_bytes);
    next_ptr    = (base_ptr + ADDR_W'(footprint)) & ring_mask;
    trunc_total = ((state_q == S_DATA) & trunc_q) | ~can_write;
    ovf_set     = frame_end & keep_w & ~(fits & ~trunc_total);
    rok_set     = (state_q == S_COMMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      wr_ptr_q    <= '0;
      cur_q       <= '0;
      next_q      <= '0;
      cnt_q       <= '0;
      trunc_q     <= 1'b0;
      hdr_q       <= '0;
      hidx_q      <= '0;
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
    end else begin
      mem_we_q <= 1'b0;
      case (state_q)
        S_IDLE, S_DATA: begin
          if (frame_byte) begin
            cur_q   <= base_ptr;
            cnt_q   <= new_len;
            trunc_q <= trunc_total;
            if (can_write) begin
              mem_we_q    <= 1'b1;
              mem_addr_q  <= byte_addr;
              mem_wdata_q <= in_data;
            end
            if (in_eof) begin
              if (keep_w && fits && !trunc_total) begin
                hdr_q   <= {new_len, status_w};
                next_q  <= next_ptr;
                hidx_q  <= '0;
                state_q <= S_HDR;
              end else begin
                state_q <= S_IDLE;
              end
            end else begin
              state_q <= S_DATA;
            end
          end
        end
        S_HDR: begin
          mem_we_q    <= 1'b1;
          mem_addr_q  <= (cur_q + ADDR_W'(hidx_q)) & ring_mask;
          mem_wdata_q <= hdr_q[{hidx_q, 3'b000} +: 8];
          hidx_q      <= hidx_q + 2'd1;
          if (hidx_q == 2'd3) state_q <= S_COMMIT;
        end
        default: begin
          wr_ptr_q <= next_q;
          state_q  <= S_IDLE;
        end
      endcase
    end
  end

  assign mem_we    = mem_we_q;
  assign mem_addr  = mem_addr_q;
  assign mem_wdata = mem_wdata_q;
  assign wr_ptr    = wr_ptr_q;
  assign buf_empty = empty_w;
  assign irq_rok   = irq_vec[0];
  assign irq_ovf   = irq_vec[1];
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic              buf_empty,
  input logic              irq_rok,
  input logic              irq_ovf,
  input logic              ic_we,
  input logic [15:0]       ic_data,
  input logic [ADDR_W-1:0] rd_off,
  input logic [ADDR_W-1:0] mask,
  input logic              ovf_set,
  input logic              rok_set
);
  AST_HDR_BEFORE_PTR: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr != $past(wr_ptr)) |-> ($past(mem_we) && ($past(mem_addr) == ($past(wr_ptr) + ADDR_W'(3))))); // R3

  AST_ROK_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr != $past(wr_ptr)) |-> irq_rok); // R10

  AST_ROK_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    rok_set |=> irq_rok); // R10

  AST_OVF_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (ic_we && ic_data[4] && !ovf_set) |=> !irq_ovf); // R10

  AST_NO_WRITE_AT_RD: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !buf_empty) |-> (mem_addr != rd_off)); // R9

  AST_ADDR_IN_RING: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((mem_addr & ~mask) == '0)); // R2
endmodule

bind rx_ring_writer rxr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_we(mem_we), .mem_addr(mem_addr),
  .wr_ptr(wr_ptr), .buf_empty(buf_empty), .irq_rok(irq_rok), .irq_ovf(irq_ovf),
  .ic_we(host_ic_we), .ic_data(host_ic_data), .rd_off(rd_off), .mask(ring_mask),
  .ovf_set(ovf_set), .rok_set(rok_set)
);

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic [1:0]  cfg_size;
  logic [5:0]  cfg_accept;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_data;
  logic        in_err_align, in_err_crc, in_err_symbol;
  logic        in_bcast, in_mcast, in_phys;
  logic        host_rp_we, host_ic_we;
  logic [15:0] host_rp_data, host_ic_data;
  logic        mem_we;
  logic [14:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [14:0] wr_ptr;
  logic        buf_empty, irq_rok, irq_ovf;

  rx_ring_writer dut_i (
    .clk(clk), .rst(rst), .cfg_size(cfg_size), .cfg_accept(cfg_accept),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .in_err_align(in_err_align), .in_err_crc(in_err_crc), .in_err_symbol(in_err_symbol),
    .in_bcast(in_bcast), .in_mcast(in_mcast), .in_phys(in_phys),
    .host_rp_we(host_rp_we), .host_rp_data(host_rp_data),
    .host_ic_we(host_ic_we), .host_ic_data(host_ic_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wr_ptr(wr_ptr), .buf_empty(buf_empty), .irq_rok(irq_rok), .irq_ovf(irq_ovf)
  );

  typedef struct {
    int off;
    int len;
    int seed;
    int st;
    int nxt;
  } exp_t;

  exp_t       expq[$];
  logic [7:0] shadow [0:32767];
  int n_chk = 0, n_bad = 0;
  int ewp = 0, hostv = 16'hFFF0, msk = 8191;
  bit exp_rok = 0, exp_ovf = 0;
  int last_wp = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: mirrors memory writes and checks each commit.
  always @(negedge clk) begin
    exp_t e;
    int bad;
    int hw;
    if (mem_we) shadow[mem_addr] = mem_wdata;
    if (!rst && int'(wr_ptr) != last_wp) begin
      if (expq.size() == 0) begin
        chk(0, "R11", "unexpected pointer move", int'(wr_ptr), last_wp);
      end else begin
        e = expq.pop_front();
        hw = {shadow[e.off+3], shadow[e.off+2], shadow[e.off+1], shadow[e.off]};
        chk(hw[15:0] == e.st[15:0], "R4", "status half", hw[15:0], e.st);
        chk(hw[31:16] == e.len[15:0], "R3", "length half", hw[31:16], e.len);
        bad = 0;
        for (int i = 0; i < e.len; i++)
          if (shadow[(e.off + 4 + i) & msk] != 8'((e.seed + i) & 255)) bad++;
        chk(bad == 0, "R2", "data bytes wrong", bad, 0);
        chk(int'(wr_ptr) == e.nxt, "R5", "next pointer", int'(wr_ptr), e.nxt);
      end
    end
    last_wp = rst ? 0 : int'(wr_ptr);
  end

  task automatic do_reset(int size);
    @(negedge clk);
    rst = 1'b1; cfg_size = 2'(size);
    in_valid = 0; in_sof = 0; in_eof = 0; in_data = 0;
    in_err_align = 0; in_err_crc = 0; in_err_symbol = 0;
    in_bcast = 0; in_mcast = 0; in_phys = 0;
    host_rp_we = 0; host_rp_data = 0; host_ic_we = 0; host_ic_data = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ewp = 0; hostv = 16'hFFF0; msk = (8192 << size) - 1;
    exp_rok = 0; exp_ovf = 0;
    expq.delete();
    @(negedge clk);
    chk(wr_ptr == 0, "R1", "reset pointer", int'(wr_ptr), 0);
    chk(buf_empty && !irq_rok && !irq_ovf && !mem_we, "R1", "reset flags",
        {buf_empty, irq_rok, irq_ovf, mem_we}, 4'b1000);
  endtask

  task automatic host_rp(int v);
    @(negedge clk);
    host_rp_we = 1'b1; host_rp_data = 16'(v);
    @(negedge clk);
    host_rp_we = 1'b0;
    hostv = v & 16'hFFFF;
  endtask

  task automatic host_ic(int v);
    @(negedge clk);
    host_ic_we = 1'b1; host_ic_data = 16'(v);
    @(negedge clk);
    host_ic_we = 1'b0;
    if (v[0]) exp_rok = 0;
    if (v[4]) exp_ovf = 0;
  endtask

  task automatic consume();
    host_rp((ewp - 16) & 16'hFFFF);
    chk(buf_empty == 1'b1, "R8", "empty after consume", buf_empty, 1);
  endtask

  // Driver: predicts the outcome, queues it, then streams the bytes.
  task automatic send_frame(int len, int seed, bit bc, bit mc, bit ph,
                            bit al, bit crc, bit sym, bit clr_hit, string req);
    bit runt, tl, hard, aok, keep, will;
    int st, rdo, diff, fr, fp, nxt;
    exp_t e;
    runt = (len < 64); tl = (len > 1518);
    hard = al | crc | tl | sym;
    st = int'(!(hard | runt)) | (int'(al) << 1) | (int'(crc) << 2) | (int'(tl) << 3) |
         (int'(runt) << 4) | (int'(sym) << 5) | (int'(bc) << 13) | (int'(ph) << 14) |
         (int'(mc) << 15);
    aok = (bc && cfg_accept[3]) || (mc && cfg_accept[2]) || (ph && cfg_accept[1]) ||
          (cfg_accept[0] && !bc && !mc);
    keep = aok && (!hard || cfg_accept[5]) && (!runt || cfg_accept[4]);
    rdo  = (hostv + 16) & msk;
    diff = (rdo - ewp) & msk;
    fr   = (diff == 0) ? msk + 1 : diff;
    fp   = (len + 4 + 3) & ~3;
    will = keep && (fp < fr);
    nxt  = (ewp + fp) & msk;
    if (will) begin
      e.off = ewp; e.len = len; e.seed = seed; e.st = st; e.nxt = nxt;
      expq.push_back(e);
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1);
      in_data = 8'((seed + i) & 255);
      in_err_align = al; in_err_crc = crc; in_err_symbol = sym;
      in_bcast = bc; in_mcast = mc; in_phys = ph;
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk);
    if (clr_hit) begin host_ic_we = 1'b1; host_ic_data = 16'h0011; end
    @(negedge clk);
    host_ic_we = 1'b0;
    repeat (4) @(negedge clk);
    if (clr_hit) exp_ovf = 0;
    if (will) begin
      chk(expq.size() == 0, req, "frame not committed", expq.size(), 0);
      ewp = nxt;
      exp_rok = 1;
    end else begin
      chk(int'(wr_ptr) == ewp, req, "pointer moved on dropped frame", int'(wr_ptr), ewp);
      if (keep) exp_ovf = 1;
    end
    chk(irq_rok == exp_rok, "R10", "irq_rok", irq_rok, exp_rok);
    chk(irq_ovf == exp_ovf, "R10", "irq_ovf", irq_ovf, exp_ovf);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int rdo, st0;
    bit sent_ok;
    cfg_accept = 6'h0E;
    do_reset(0);

    send_frame(64, 1, 0, 0, 1, 0, 0, 0, 0, "R5");
    chk(buf_empty == 1'b0, "R8", "not empty after commit", buf_empty, 0);
    send_frame(65, 7, 1, 0, 0, 0, 0, 0, 0, "R6");
    host_ic(16'h0001);
    cfg_accept = 6'h0A;
    send_frame(80, 3, 0, 1, 0, 0, 0, 0, 0, "R11");       // R6 multicast rejected
    cfg_accept = 6'h0E;
    send_frame(80, 9, 0, 1, 0, 0, 0, 0, 0, "R6");        // multicast accepted
    send_frame(70, 5, 0, 0, 1, 0, 1, 0, 0, "R7");        // CRC frame dropped
    cfg_accept = 6'h2E;
    send_frame(70, 5, 0, 0, 1, 0, 1, 0, 0, "R7");        // CRC frame kept
    send_frame(30, 11, 0, 0, 1, 0, 0, 0, 0, "R7");       // runt dropped
    cfg_accept = 6'h3E;
    send_frame(30, 11, 0, 0, 1, 0, 0, 0, 0, "R7");       // runt kept
    send_frame(70, 13, 0, 0, 1, 1, 0, 1, 0, "R4");       // align + symbol
    cfg_accept = 6'h01;
    send_frame(66, 17, 0, 0, 0, 0, 0, 0, 0, "R6");       // any unicast
    send_frame(66, 19, 1, 0, 0, 0, 0, 0, 0, "R6");       // broadcast rejected
    consume();
    cfg_accept = 6'h3E;
    send_frame(1600, 21, 0, 0, 1, 0, 0, 0, 0, "R4");     // too long, kept
    consume();

    // R9: read offset 64 bytes ahead of the write pointer.
    host_rp((ewp + 64 - 16) & 16'hFFFF);
    rdo = (ewp + 64) & msk;
    for (int k = 0; k < 8; k++) shadow[(rdo + k) & msk] = 8'hA5;
    send_frame(64, 23, 0, 0, 1, 0, 0, 0, 0, "R9");
    st0 = 0;
    for (int k = 0; k < 8; k++) if (shadow[(rdo + k) & msk] != 8'hA5) st0++;
    chk(st0 == 0, "R9", "bytes overwritten at read offset", st0, 0);
    send_frame(56, 29, 0, 0, 1, 0, 0, 0, 0, "R9");       // fits: 60 < 64
    consume();

    // R10: clear issued in the commit cycle.
    host_ic(16'h0001);
    chk(irq_rok == 1'b0, "R10", "rok cleared", irq_rok, 0);
    send_frame(64, 31, 0, 0, 1, 0, 0, 0, 1, "R10");

    // R2: wrap across the end of an 8 KiB ring.
    for (int f = 0; f < 6; f++) begin
      consume();
      send_frame(1500, 40 + f, 0, 0, 1, 0, 0, 0, 0, "R2");
    end

    // R2: 16 KiB ring does not wrap at 8 KiB.
    do_reset(1);
    cfg_accept = 6'h0E;
    for (int f = 0; f < 6; f++) begin
      consume();
      send_frame(1500, 60 + f, 0, 0, 1, 0, 0, 0, 0, "R2");
    end
    chk(int'(wr_ptr) == 9024, "R2", "pointer in 16 KiB ring", int'(wr_ptr), 9024);
    sent_ok = 1;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule